// File: doc/BRIEF.md
# Serial Flash Page-Program Responder

This block is the memory-side end of a serial configuration flash link. It runs in the system clock domain and samples chip select, serial clock and serial data in on that clock. From the sampled stream it decodes one-byte commands: one arms writing, one reports status and one programs a page. A program command carries a 24-bit address and a stream of data bytes. The data is collected in a 256-byte page buffer that wraps inside the addressed page. When chip select is released cleanly, the buffer is committed to a small internal byte array and a self-timed busy interval begins.

Status is returned on serial data out, which changes on falling serial clock edges. A debug port reads the array combinationally, so a test environment can inspect the stored contents without running a serial read. The array holds `2**ADDR_W` bytes. Address bits above the array width are ignored.

Top module: `spf_responder`

## Requirements
- R1: After reset the array reads 0xFF at every address, the write-arm flag and the busy flag are 0, and serial data out is 0.
- R2: Command byte 0x06 sets the write-arm flag when the block is not busy.
- R3: Command byte 0x05 returns a status byte with busy at bit 0, write-arm at bit 1 and zeros above. It is shifted out most significant bit first, one bit per falling serial clock edge. The byte repeats for as long as clocking continues, and each repeat carries fresh values.
- R4: Command byte 0x02 issued while the write-arm flag is 0 writes nothing and does not start a busy interval.
- R5: Program data is stored from the address given by the three bytes after 0x02 (most significant byte first). When the data passes offset 0xFF of the page, it wraps to offset 0x00 of the same page. Page bytes that receive no data keep their contents, and address bits at or above ADDR_W are ignored.
- R6: When more than 256 data bytes are sent, each page offset holds the last byte that was sent to it.
- R7: A program is committed only if chip select rises after a whole number of data bytes, with at least one data byte. Otherwise nothing is written, no busy interval starts and the write-arm flag keeps its value.
- R8: A committed program clears the write-arm flag and holds busy at 1 for exactly BUSY_CYCLES clock cycles, starting on the clock after chip select rises.
- R9: While busy, commands other than 0x05 are ignored. In particular, 0x06 does not set the write-arm flag.
- R10: Serial data out is 0 on every cycle after a clock edge that samples chip select high.
- R11: The debug port returns the current array byte at the debug address in the same cycle, including right after a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; all serial inputs are sampled on it |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock; data is taken in on its rising edge |
| sdi_i | input | 1 | Serial data in, most significant bit first |
| sdo_o | output | 1 | Serial data out for status reads |
| dbg_addr_i | input | ADDR_W | Debug read address into the array |
| dbg_data_o | output | 8 | Array byte at the debug address |

## Verification
The bench drives a start address near the end of a page so that the data wraps. A design that carried the data into the next page would corrupt that page, and one that cleared untouched bytes would lose data outside the written range. A 300-byte program checks that the later bytes overwrite the earlier ones at the same offsets; keeping the first bytes instead would leave stale values at the start of the page. The bench releases chip select three bits into a byte and again right after the address. A design that committed on either release would write the array and raise busy. The bench also sends a write-arm command while the block is busy; a design that accepted it would report bit 1 set in the status bytes that follow.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_RDST = 8'h05;
  localparam logic [7:0] OP_WARM = 8'h06;

  typedef enum logic [1:0] {
    PH_CMD,
    PH_ADDR,
    PH_DATA,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/spf_link.sv
module spf_link (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sclk_i,
  input  logic       sdi_i,
  input  logic [7:0] status_i,
  input  logic       rd_arm_i,
  output logic [7:0] byte_o,
  output logic       byte_vld_o,
  output logic       cs_rise_o,
  output logic       on_bound_o,
  output logic       sdo_o
);
  logic       sclk_q, cs_q;
  logic [2:0] bit_cnt_q;
  logic [6:0] shreg_q;
  logic [7:0] out_sr_q;
  logic [2:0] out_cnt_q;
  logic       out_act_q;
  logic       sclk_rise, sclk_fall;

  assign sclk_rise  = sclk_i & ~sclk_q & ~cs_ni;
  assign sclk_fall  = ~sclk_i & sclk_q & ~cs_ni;
  assign cs_rise_o  = cs_ni & ~cs_q;
  assign on_bound_o = (bit_cnt_q == 3'd0);
  assign byte_vld_o = sclk_rise && (bit_cnt_q == 3'd7);
  assign byte_o     = {shreg_q, sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
    end
  end

  // input shifter, bit count restarts on every deselect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      shreg_q   <= '0;
    end else if (cs_ni) begin
      bit_cnt_q <= '0;
    end else if (sclk_rise) begin
      shreg_q   <= {shreg_q[5:0], sdi_i};
      bit_cnt_q <= bit_cnt_q + 3'd1;
    end
  end

  // status output, reloaded with live status after each byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_sr_q  <= '0;
      out_cnt_q <= '0;
      out_act_q <= 1'b0;
      sdo_o     <= 1'b0;
    end else if (cs_ni) begin
      out_act_q <= 1'b0;
      out_cnt_q <= '0;
      sdo_o     <= 1'b0;
    end else if (rd_arm_i) begin
      out_sr_q  <= status_i;
      out_cnt_q <= '0;
      out_act_q <= 1'b1;
    end else if (out_act_q && sclk_fall) begin
      sdo_o     <= out_sr_q[7];
      out_cnt_q <= out_cnt_q + 3'd1;
      if (out_cnt_q == 3'd7) out_sr_q <= status_i;
      else                   out_sr_q <= {out_sr_q[6:0], 1'b0};
    end
  end
endmodule

// File: rtl/spf_pagebuf.sv
module spf_pagebuf #(
  parameter int PAGE_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  start_i,
  input  logic [PAGE_W-1:0]     start_ptr_i,
  input  logic                  wr_i,
  input  logic [7:0]            wr_data_i,
  output logic [7:0]            data_o [2**PAGE_W],
  output logic [2**PAGE_W-1:0]  valid_o
);
  logic [PAGE_W-1:0] ptr_q;

  // pointer wraps inside the page by width
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (start_i) ptr_q <= start_ptr_i;
    else if (wr_i)    ptr_q <= ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    valid_o <= '0;
    else if (clr_i) valid_o <= '0;
    else if (wr_i)  valid_o[ptr_q] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) data_o[ptr_q] <= wr_data_i;
  end
endmodule

// File: rtl/spf_array.sv
module spf_array #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       commit_i,
  input  logic [ADDR_W-PAGE_W-1:0]   page_i,
  input  logic [7:0]                 wdata_i [2**PAGE_W],
  input  logic [2**PAGE_W-1:0]       wvalid_i,
  input  logic [ADDR_W-1:0]          dbg_addr_i,
  output logic [7:0]                 dbg_data_o
);
  localparam int PG_W       = ADDR_W - PAGE_W;
  localparam int NPAGES     = 2**PG_W;
  localparam int PAGE_BYTES = 2**PAGE_W;

  logic [7:0] pg_rd [NPAGES];

  for (genvar g = 0; g < NPAGES; g++) begin : g_page
    logic [7:0] cell_q [PAGE_BYTES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < PAGE_BYTES; i++) cell_q[i] <= 8'hFF;
      end else if (commit_i && page_i == PG_W'(g)) begin
        for (int i = 0; i < PAGE_BYTES; i++)
          if (wvalid_i[i]) cell_q[i] <= wdata_i[i];
      end
    end

    assign pg_rd[g] = cell_q[dbg_addr_i[PAGE_W-1:0]];
  end

  assign dbg_data_o = pg_rd[dbg_addr_i[ADDR_W-1:PAGE_W]];
endmodule

// File: rtl/spf_responder.sv
module spf_responder
  import spf_pkg::*;
#(
  parameter int ADDR_W      = 9,
  parameter int BUSY_CYCLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic [ADDR_W-1:0] dbg_addr_i,
  output logic [7:0]        dbg_data_o
);
  localparam int PAGE_W     = 8;
  localparam int PAGE_BYTES = 2**PAGE_W;
  localparam int PG_W       = ADDR_W - PAGE_W;
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1);

  phase_e              phase_q;
  logic [1:0]          addr_idx_q;
  logic [23:0]         addr_q;
  logic                got_data_q;
  logic                wel_q, wip_q;
  logic [CNT_W-1:0]    busy_cnt_q;

  logic [7:0]          rx_byte;
  logic                rx_vld, cs_rise, on_bound;
  logic                rd_arm, buf_clr, buf_start, buf_wr, commit;
  logic [7:0]          status;
  logic [7:0]          buf_data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] buf_valid;

  assign status    = {6'b0, wel_q, wip_q};
  assign rd_arm    = rx_vld && phase_q == PH_CMD && rx_byte == OP_RDST;
  assign buf_clr   = rx_vld && phase_q == PH_CMD && rx_byte == OP_PROG && wel_q && !wip_q;
  assign buf_start = rx_vld && phase_q == PH_ADDR && addr_idx_q == 2'd2;
  assign buf_wr    = rx_vld && phase_q == PH_DATA;
  // commit only on a clean byte-aligned release after data
  assign commit    = cs_rise && phase_q == PH_DATA && got_data_q && on_bound;

  spf_link u_link (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sclk_i     (sclk_i),
    .sdi_i      (sdi_i),
    .status_i   (status),
    .rd_arm_i   (rd_arm),
    .byte_o     (rx_byte),
    .byte_vld_o (rx_vld),
    .cs_rise_o  (cs_rise),
    .on_bound_o (on_bound),
    .sdo_o      (sdo_o)
  );

  spf_pagebuf #(.PAGE_W(PAGE_W)) u_buf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (buf_clr),
    .start_i     (buf_start),
    .start_ptr_i (rx_byte),
    .wr_i        (buf_wr),
    .wr_data_i   (rx_byte),
    .data_o      (buf_data),
    .valid_o     (buf_valid)
  );

  spf_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_arr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .commit_i   (commit),
    .page_i     (addr_q[PAGE_W +: PG_W]),
    .wdata_i    (buf_data),
    .wvalid_i   (buf_valid),
    .dbg_addr_i (dbg_addr_i),
    .dbg_data_o (dbg_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_CMD;
      addr_idx_q <= '0;
      addr_q     <= '0;
      got_data_q <= 1'b0;
      wel_q      <= 1'b0;
      wip_q      <= 1'b0;
      busy_cnt_q <= '0;
    end else begin
      if (commit) begin
        wel_q      <= 1'b0;
        wip_q      <= 1'b1;
        busy_cnt_q <= CNT_W'(BUSY_CYCLES - 1);
      end else if (wip_q) begin
        if (busy_cnt_q == '0) wip_q <= 1'b0;
        else                  busy_cnt_q <= busy_cnt_q - 1'b1;
      end

      if (cs_ni) begin
        phase_q    <= PH_CMD;
        got_data_q <= 1'b0;
      end else if (rx_vld) begin
        unique case (phase_q)
          PH_CMD: begin
            phase_q <= PH_SKIP;
            if (rx_byte == OP_WARM && !wip_q) wel_q <= 1'b1;
            if (buf_clr) begin
              phase_q    <= PH_ADDR;
              addr_idx_q <= '0;
            end
          end
          PH_ADDR: begin
            addr_q     <= {addr_q[15:0], rx_byte};
            addr_idx_q <= addr_idx_q + 2'd1;
            if (addr_idx_q == 2'd2) phase_q <= PH_DATA;
          end
          PH_DATA: got_data_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
  parameter int BUSY_CYCLES = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic sdo_o,
  input logic wel,
  input logic wip,
  input logic commit
);
  logic [31:0] wip_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  wip_run <= '0;
    else if (wip) wip_run <= wip_run + 32'd1;
    else          wip_run <= '0;
  end

  // R8
  wip_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip) |-> $past(cs_ni) && !$past(cs_ni, 2));

  // R8
  wel_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> !wel && wip);

  // R8
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_run <= BUSY_CYCLES);

  // R8
  busy_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip) |-> wip_run == BUSY_CYCLES);

  // R9
  wel_idle_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel) |-> !$past(wip));

  // R10
  sdo_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !sdo_o);

  // R7
  commit_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> cs_ni && wel);
endmodule

bind spf_responder spf_checker #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_ni  (cs_ni),
  .sdo_o  (sdo_o),
  .wel    (wel_q),
  .wip    (wip_q),
  .commit (commit)
);

// File: tb/sim_spf_responder.sv
module sim_spf_responder;
  localparam int AW = 9;
  localparam int BC = 100;
  localparam int H  = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_ni = 1'b0;
  logic          cs_ni  = 1'b1;
  logic          sclk   = 1'b0;
  logic          sdi    = 1'b0;
  logic [AW-1:0] dbg_addr = '0;
  logic          sdo;
  logic [7:0]    dbg_data;

  spf_responder #(.ADDR_W(AW), .BUSY_CYCLES(BC)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sclk_i     (sclk),
    .sdi_i      (sdi),
    .sdo_o      (sdo),
    .dbg_addr_i (dbg_addr),
    .dbg_data_o (dbg_data)
  );

  int         n_tests = 0;
  int         n_fail  = 0;
  bit         done    = 0;
  logic [7:0] exp_mem [2**AW];
  bit         exp_wel = 0;
  int         busy_left = 0;
  bit         commit_pend = 0;
  logic [7:0] stg [256];
  bit         stg_v [256];
  int         stg_page = 0;
  bit         pre_wip, pre_wel;

  function automatic logic [7:0] dat(int k, int seed);
    logic [7:0] base;
    base = 8'(k * 13 + seed);
    return (k >= 256) ? (base ^ 8'h5A) : base;
  endfunction

  task automatic chk(bit ok, string req, int act, int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // one clock; model state advances with the edge, then outputs compared
  task automatic step();
    @(posedge clk);
    #1;
    if (commit_pend) begin
      for (int i = 0; i < 256; i++)
        if (stg_v[i]) exp_mem[stg_page * 256 + i] = stg[i];
      busy_left   = BC;
      commit_pend = 0;
      exp_wel     = 0;
    end else if (busy_left > 0) begin
      busy_left--;
    end
    chk(dbg_data === exp_mem[dbg_addr], "R11 debug read", dbg_data, exp_mem[dbg_addr]);
    if (cs_ni) chk(sdo === 1'b0, "R10 sdo idle", sdo, 0);
    dbg_addr = dbg_addr + 1'b1;
  endtask

  task automatic send_bit(bit b);
    sdi  = b;
    sclk = 1'b0;
    repeat (H) step();
    pre_wip = (busy_left > 0);
    pre_wel = exp_wel;
    sclk = 1'b1;
    repeat (H) step();
  endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic cs_lo();
    sclk  = 1'b0;
    cs_ni = 1'b0;
    step();
  endtask

  task automatic cs_hi();
    sclk  = 1'b0;
    cs_ni = 1'b1;
    step();
    step();
  endtask

  task automatic cmd_warm();
    cs_lo();
    send_byte(8'h06);
    if (!pre_wip) exp_wel = 1;
    cs_hi();
  endtask

  task automatic cmd_rdst(int nbytes, string req);
    logic [7:0] cur, nxt;
    cs_lo();
    send_byte(8'h05);
    cur = {6'b0, pre_wel, pre_wip};
    nxt = cur;
    for (int k = 0; k < nbytes; k++) begin
      for (int j = 7; j >= 0; j--) begin
        if (j == 0) nxt = {6'b0, exp_wel, (busy_left > 0)};
        sclk = 1'b0;
        sdi  = 1'b0;
        step();
        chk(sdo === cur[j], req, sdo, cur[j]);
        repeat (H - 1) step();
        sclk = 1'b1;
        repeat (H) step();
      end
      cur = nxt;
    end
    cs_hi();
  endtask

  task automatic cmd_prog(logic [23:0] addr, int n, int seed, int extra);
    bit acc;
    int pos;
    cs_lo();
    send_byte(8'h02);
    acc = pre_wel && !pre_wip;
    send_byte(addr[23:16]);
    send_byte(addr[15:8]);
    send_byte(addr[7:0]);
    for (int i = 0; i < 256; i++) stg_v[i] = 0;
    for (int k = 0; k < n; k++) begin
      send_byte(dat(k, seed));
      pos = (int'(addr[7:0]) + k) % 256;
      stg[pos]   = dat(k, seed);
      stg_v[pos] = 1;
    end
    for (int e = 0; e < extra; e++) send_bit(e[0]);
    stg_page = int'(addr[AW-1:8]);
    if (acc && n > 0 && extra == 0) commit_pend = 1;
    cs_hi();
  endtask

  task automatic wait_idle();
    while (busy_left > 0) step();
    step();
  endtask

  task automatic peek(int a, logic [7:0] expv, string req);
    dbg_addr = AW'(a);
    #1;
    chk(dbg_data === expv, req, dbg_data, expv);
  endtask

  initial begin
    for (int i = 0; i < 2**AW; i++) exp_mem[i] = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    step();

    // R1 reset contents and status
    for (int i = 0; i < 2**AW; i++) peek(i, 8'hFF, "R1 erased after reset");
    cmd_rdst(1, "R1 R3 status after reset");

    // R4 program without arming
    cmd_prog(24'h000010, 3, 1, 0);
    cmd_rdst(1, "R4 no busy after unarmed program");
    peek(16'h010, 8'hFF, "R4 unarmed program wrote nothing");

    // R2 arm, R3 status shows bit 1
    cmd_warm();
    cmd_rdst(2, "R2 R3 armed status");

    // R5 wrap inside page 0, R8 busy then idle
    cmd_prog(24'h0000F0, 20, 5, 0);
    cmd_rdst(3, "R8 status during busy");
    wait_idle();
    cmd_rdst(1, "R8 status after busy");
    peek(16'h0F0, dat(0, 5),  "R5 first byte at start address");
    peek(16'h0FF, dat(15, 5), "R5 last byte of page");
    peek(16'h000, dat(16, 5), "R5 wrap to page offset 0");
    peek(16'h003, dat(19, 5), "R5 wrapped tail");
    peek(16'h004, 8'hFF,      "R5 untouched byte kept");
    peek(16'h0EF, 8'hFF,      "R5 byte before start kept");
    peek(16'h100, 8'hFF,      "R5 next page untouched");

    // R6 long program, R9 arming ignored while busy
    cmd_warm();
    cmd_prog(24'h000105, 300, 9, 0);
    cmd_warm();
    cmd_rdst(2, "R9 arm ignored while busy");
    wait_idle();
    cmd_rdst(1, "R9 arm still clear after busy");
    peek(16'h105, dat(256, 9), "R6 later byte replaces earlier");
    peek(16'h104, dat(255, 9), "R6 byte at offset 4");
    peek(16'h130, dat(299, 9), "R6 last byte sent");
    peek(16'h131, dat(44, 9),  "R6 oldest kept byte");

    // R7 release off a byte boundary and with no data
    cmd_warm();
    cmd_prog(24'h000040, 4, 3, 3);
    cmd_rdst(1, "R7 aborted program leaves arm set and idle");
    peek(16'h040, 8'hFF, "R7 partial byte release wrote nothing");
    cmd_prog(24'h000050, 0, 3, 0);
    cmd_rdst(1, "R7 no-data program leaves arm set");
    peek(16'h050, 8'hFF, "R7 no-data release wrote nothing");

    // R5 high address bits ignored
    cmd_prog(24'hFFFE30, 2, 11, 0);
    wait_idle();
    peek(16'h030, dat(0, 11), "R5 high address bits ignored");
    peek(16'h031, dat(1, 11), "R5 second byte");
    peek(16'h130, dat(299, 9), "R5 other page unchanged");

    // R11 full sweep against model
    for (int i = 0; i < 2**AW; i++) peek(i, exp_mem[i], "R11 final sweep");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule